// File: doc/BRIEF.md
# Programmable Calculator Control Sequencer

This block is the control path of a small programmable floating-point calculator. It walks a 16-bit-wide program memory from address zero, decodes each instruction, reads operands from an eight-entry register file of 32-bit single-precision values, and hands arithmetic work to an external arithmetic unit through a start/done handshake. It then writes either the unit's result or an immediate constant back into the register file.

The stages never overlap. Each stage starts only when the one before it reports completion, and each has a fixed length. A program ends on an all-zero word, and the block then stays halted. If the arithmetic unit reports an exception, or an instruction word cannot be decoded, the block freezes and an indicator output blinks. In both cases only reset restarts the block. The register-file write port is visible at the block's outputs, so the surrounding logic can observe each result as it is committed.

Top module: `calc_sequencer`

## Requirements
- R1: After reset `pm_addr` is 0, and `halted`, `suspended`, `blink`, `au_start` and `wr_en` are all 0.
- R2: An arithmetic word is laid out as opcode[15:12], destination[11:9], source1[8:6], source2[5:3], with bits[2:0] zero. Opcodes 1, 2, 3 and 4 select add, subtract, multiply and divide, and these are issued on `au_op` as 0, 1, 2 and 3. `au_a` and `au_b` carry the register contents addressed by source1 and source2. The returned `au_result` is written to the destination register.
- R3: Opcode 5 is a move. It uses three consecutive words: the opcode word (destination in [11:9]), then the upper 16 bits of the constant, then the lower 16 bits. The constant is written to the destination without any `au_start`. The program counter advances by 3 for a move and by 1 for an arithmetic word.
- R4: Fixed timing applies in three places. `au_start` rises 6 cycles after the `wr_en` cycle of the preceding instruction. `wr_en` rises 3 cycles after the cycle in which `au_done` is presented. Two back-to-back moves have their `wr_en` pulses 8 cycles apart.
- R5: `au_start` is a single-cycle pulse per arithmetic instruction.
- R6: The word 16'h0000 sets `halted`. After that, `pm_addr` stays on the address of that word, no further writes occur, and `halted` and `suspended` are never both 1.
- R7: When `au_done` arrives with `au_exc` high, `suspended` is set and the result is not written. While suspended, `blink` toggles every 2^BLINK_LOG2 cycles. While not suspended, `blink` stays 0.
- R8: An opcode of 6 to 15, or opcode 0 with any other bit set, sets `suspended` without any write. No write ever occurs while halted or suspended.
- R9: Reset leaves the halted or suspended state and restarts fetching at address 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_addr | output | PC_W | Program memory address (registered program counter) |
| pm_data | input | 16 | Program memory word at `pm_addr`, combinational read |
| au_start | output | 1 | One-cycle request to the arithmetic unit |
| au_op | output | 2 | Operation: 0 add, 1 subtract, 2 multiply, 3 divide |
| au_a | output | 32 | First operand |
| au_b | output | 32 | Second operand |
| au_done | input | 1 | Arithmetic unit finished |
| au_exc | input | 1 | Exception flag, valid with `au_done` |
| au_result | input | 32 | Result, valid with `au_done` |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | 3 | Register being written |
| wr_data | output | 32 | Value being written |
| halted | output | 1 | Program ended normally |
| suspended | output | 1 | Frozen by an exception or a bad word |
| blink | output | 1 | Exception indicator |

## Verification
The hardest state to reach from the ports is the suspension that follows an arithmetic exception. It needs valid operands in the registers, a full fetch-decode-read-issue sequence, and an exception flag that is presented in exactly the cycle `au_done` is returned. The bench reaches it by loading two moves and an add, and by arming its stand-in arithmetic unit to raise the flag on its next response, after a randomised delay. It then confirms that nothing was written for that add and measures the blink period between successive toggles. The timing requirement is checked by time-stamping every `wr_en`, `au_start` and `au_done` during a full eight-instruction program.

// File: rtl/calc_pkg.sv
package calc_pkg;
  localparam int IW    = 16;  // program word width
  localparam int DW    = 32;  // register / constant width
  localparam int RA_W  = 3;   // register address width
  localparam int NREG  = 8;

  localparam logic [3:0] OPC_HALT = 4'd0;
  localparam logic [3:0] OPC_ADD  = 4'd1;
  localparam logic [3:0] OPC_DIV  = 4'd4;
  localparam logic [3:0] OPC_MOVE = 4'd5;

  typedef enum logic [1:0] {K_HALT, K_ARITH, K_MOVE, K_BAD} kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [1:0]      op;
    logic [RA_W-1:0] dst;
    logic [RA_W-1:0] s1;
    logic [RA_W-1:0] s2;
  } dec_t;

  typedef enum logic [3:0] {
    S_FETCH, S_CHI, S_CLO, S_DEC1, S_DEC2, S_RD, S_EXEC, S_WAIT,
    S_WB1, S_WB2, S_WR, S_HALT, S_SUSP
  } state_e;
endpackage

// File: rtl/calc_decode.sv
module calc_decode
  import calc_pkg::*;
(
  input  logic [IW-1:0] word,
  output dec_t          dec
);
  logic [3:0] opc;
  logic [3:0] op_m1;

  always_comb begin
    opc      = word[15:12];
    op_m1    = opc - 4'd1;
    dec.op   = op_m1[1:0];
    dec.dst  = word[11:9];
    dec.s1   = word[8:6];
    dec.s2   = word[5:3];
    if (word == '0)
      dec.kind = K_HALT;
    else if (opc >= OPC_ADD && opc <= OPC_DIV)
      dec.kind = K_ARITH;
    else if (opc == OPC_MOVE)
      dec.kind = K_MOVE;
    else
      dec.kind = K_BAD;  // covers opcode 0 with stray bits and 6..15
  end
endmodule

// File: rtl/calc_regfile.sv
module calc_regfile #(
  parameter int DEPTH = 8,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr1,
  input  logic [AW-1:0] raddr2,
  output logic [DW-1:0] rdata1,
  output logic [DW-1:0] rdata2
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata1 <= mem[raddr1];
    rdata2 <= mem[raddr2];
  end
endmodule

// File: rtl/calc_blinker.sv
module calc_blinker #(
  parameter int DIV_LOG2 = 20
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic blink
);
  logic [DIV_LOG2-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt   <= '0;
      blink <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      if (&cnt) blink <= ~blink;
    end
  end

  p_blink_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !en |=> !blink);
endmodule

// File: rtl/calc_sequencer.sv
module calc_sequencer
  import calc_pkg::*;
#(
  parameter int PC_W       = 8,
  parameter int BLINK_LOG2 = 20
) (
  input  logic            clk,
  input  logic            rst,
  output logic [PC_W-1:0] pm_addr,
  input  logic [IW-1:0]   pm_data,
  output logic            au_start,
  output logic [1:0]      au_op,
  output logic [DW-1:0]   au_a,
  output logic [DW-1:0]   au_b,
  input  logic            au_done,
  input  logic            au_exc,
  input  logic [DW-1:0]   au_result,
  output logic            wr_en,
  output logic [RA_W-1:0] wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            halted,
  output logic            suspended,
  output logic            blink
);
  state_e        st;
  dec_t          fd, dec_q;
  logic [DW-1:0] const_q, res_q, rf_q1, rf_q2;

  calc_decode u_dec (.word(pm_data), .dec(fd));

  calc_regfile #(.DEPTH(NREG), .DW(DW)) u_rf (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr1(dec_q.s1), .raddr2(dec_q.s2), .rdata1(rf_q1), .rdata2(rf_q2)
  );

  calc_blinker #(.DIV_LOG2(BLINK_LOG2)) u_blink (
    .clk(clk), .rst(rst), .en(suspended), .blink(blink)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_FETCH;
      pm_addr   <= '0;
      dec_q     <= '0;
      const_q   <= '0;
      res_q     <= '0;
      au_start  <= 1'b0;
      au_op     <= '0;
      au_a      <= '0;
      au_b      <= '0;
      wr_en     <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      halted    <= 1'b0;
      suspended <= 1'b0;
    end else begin
      unique case (st)
        S_FETCH: begin
          dec_q <= fd;
          unique case (fd.kind)
            K_HALT: begin halted <= 1'b1; st <= S_HALT; end
            K_BAD:  begin suspended <= 1'b1; st <= S_SUSP; end
            K_MOVE: begin pm_addr <= pm_addr + 1'b1; st <= S_CHI; end
            default: begin pm_addr <= pm_addr + 1'b1; st <= S_DEC1; end
          endcase
        end
        S_CHI: begin
          const_q <= {const_q[DW-IW-1:0], pm_data};
          pm_addr <= pm_addr + 1'b1;
          st      <= S_CLO;
        end
        S_CLO: begin
          const_q <= {const_q[DW-IW-1:0], pm_data};
          pm_addr <= pm_addr + 1'b1;
          st      <= S_DEC1;
        end
        S_DEC1: begin
          au_op <= dec_q.op;
          st    <= S_DEC2;
        end
        S_DEC2: st <= (dec_q.kind == K_MOVE) ? S_WB1 : S_RD;
        S_RD:   st <= S_EXEC;  // register file read in flight
        S_EXEC: begin
          au_a     <= rf_q1;
          au_b     <= rf_q2;
          au_start <= 1'b1;
          st       <= S_WAIT;
        end
        S_WAIT: begin
          au_start <= 1'b0;
          if (au_done) begin
            if (au_exc) begin
              suspended <= 1'b1;
              st        <= S_SUSP;
            end else begin
              res_q <= au_result;
              st    <= S_WB1;
            end
          end
        end
        S_WB1: begin
          wr_data <= (dec_q.kind == K_MOVE) ? const_q : res_q;
          wr_addr <= dec_q.dst;
          st      <= S_WB2;
        end
        S_WB2: begin
          wr_en <= 1'b1;
          st    <= S_WR;
        end
        S_WR: begin
          wr_en <= 1'b0;
          st    <= S_FETCH;
        end
        default: ;  // S_HALT, S_SUSP: held until reset
      endcase
    end
  end

  p_start_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    au_start |=> !au_start);
  p_halt_hold_r6: assert property (@(posedge clk) disable iff (rst)
    halted |=> halted && $stable(pm_addr));
  p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    !(halted && suspended));
  p_susp_hold_r7: assert property (@(posedge clk) disable iff (rst)
    suspended |=> suspended && $stable(pm_addr));
  p_no_write_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (halted || suspended) |-> !wr_en);
  p_no_start_stopped_r8: assert property (@(posedge clk) disable iff (rst)
    (halted || suspended) |-> !au_start);
endmodule

// File: tb/test_calc_sequencer.sv
module test_calc_sequencer;
  localparam int BL = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  pm_addr;
  logic [15:0] pm_data;
  logic        au_start, au_done, au_exc, wr_en, halted, suspended, blink;
  logic [1:0]  au_op;
  logic [31:0] au_a, au_b, au_result, wr_data;
  logic [2:0]  wr_addr;

  logic [15:0] prog [32];
  int n_chk = 0, n_err = 0, cyc = 0;
  bit exc_arm = 0;

  // write / start / done logs
  int n_wr = 0, n_st = 0, n_dn = 0;
  int wr_cyc [16]; logic [2:0] wr_a [16]; logic [31:0] wr_d [16];
  int st_cyc [16]; logic [1:0] st_op [16]; logic [31:0] st_a [16], st_b [16];
  int dn_cyc [16];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  assign pm_data = prog[pm_addr[4:0]];

  calc_sequencer #(.PC_W(8), .BLINK_LOG2(BL)) i_calc_sequencer (
    .clk(clk), .rst(rst), .pm_addr(pm_addr), .pm_data(pm_data),
    .au_start(au_start), .au_op(au_op), .au_a(au_a), .au_b(au_b),
    .au_done(au_done), .au_exc(au_exc), .au_result(au_result),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .halted(halted), .suspended(suspended), .blink(blink)
  );

  // stand-in arithmetic: integer operations on the bit patterns
  function automatic logic [31:0] fake_au(logic [1:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a * b;
      default: return a ^ (b << 1);
    endcase
  endfunction

  function automatic logic [15:0] w_ar(int opc, int d, int s1, int s2);
    return {opc[3:0], d[2:0], s1[2:0], s2[2:0], 3'b000};
  endfunction

  // arithmetic responder with random latency
  initial begin
    au_done = 0; au_exc = 0; au_result = '0;
    forever begin
      @(negedge clk);
      if (!rst && au_start) begin
        logic [1:0] op; logic [31:0] a, b; int lat;
        op = au_op; a = au_a; b = au_b;
        lat = 1 + int'($urandom_range(3));
        repeat (lat - 1) @(negedge clk);
        au_result = fake_au(op, a, b);
        au_exc = exc_arm; au_done = 1;
        if (n_dn < 16) dn_cyc[n_dn] = cyc;
        n_dn++;
        @(negedge clk);
        au_done = 0; au_exc = 0;
      end
    end
  end

  // monitor
  initial forever begin
    @(negedge clk);
    if (!rst) begin
      if (wr_en && n_wr < 16) begin
        wr_cyc[n_wr] = cyc; wr_a[n_wr] = wr_addr; wr_d[n_wr] = wr_data; n_wr++;
      end
      if (au_start && n_st < 16) begin
        st_cyc[n_st] = cyc; st_op[n_st] = au_op; st_a[n_st] = au_a; st_b[n_st] = au_b; n_st++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: run did not finish");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; exc_arm = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_wr = 0; n_st = 0; n_dn = 0;
    rst = 0;
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 32; i++) prog[i] = 16'h0000;
  endtask

  task automatic wait_stop();
    for (int i = 0; i < 2000 && !halted && !suspended; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_prog();
    prog[0] = w_ar(5, 0, 0, 0);  // keep it busy so nothing stops at once
    rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "pm_addr", pm_addr, 0);
    chk("R1", "halted", halted, 0);
    chk("R1", "suspended", suspended, 0);
    chk("R1", "blink", blink, 0);
    chk("R1", "au_start", au_start, 0);
    chk("R1", "wr_en", wr_en, 0);
  endtask

  task automatic t_program();
    logic [31:0] r [8];
    int ai [5];
    clear_prog();
    prog[0] = w_ar(5, 0, 0, 0); prog[1] = 16'h3FC0; prog[2] = 16'h0000;
    prog[3] = w_ar(5, 1, 0, 0); prog[4] = 16'h3FE0; prog[5] = 16'h0000;
    prog[6] = w_ar(2, 2, 0, 1);
    prog[7] = w_ar(4, 3, 1, 2);
    prog[8] = w_ar(5, 4, 0, 0); prog[9] = 16'h4020; prog[10] = 16'h1234;
    prog[11] = w_ar(3, 5, 3, 4);
    prog[12] = w_ar(4, 6, 2, 4);
    prog[13] = w_ar(1, 7, 5, 6);
    prog[14] = 16'h0000;
    r[0] = 32'h3FC00000; r[1] = 32'h3FE00000;
    r[2] = r[0] - r[1];
    r[3] = fake_au(3, r[1], r[2]);
    r[4] = 32'h40201234;
    r[5] = r[3] * r[4];
    r[6] = fake_au(3, r[2], r[4]);
    r[7] = r[5] + r[6];
    do_reset();
    wait_stop();
    repeat (20) @(negedge clk);
    chk("R6", "halted", halted, 1);
    chk("R6", "suspended with halt", suspended, 0);
    chk("R6", "pm_addr frozen on halt word (R3 steps 3/1)", pm_addr, 14);
    chk("R6", "write count", n_wr, 8);
    chk("R3", "no start for moves", n_st, 5);
    for (int i = 0; i < 8 && i < n_wr; i++) begin
      chk("R2", "write order addr", wr_a[i], i);
      chk(i == 0 || i == 1 || i == 4 ? "R3" : "R2", "register value", wr_d[i], r[i]);
    end
    // operations: sub, div, mul, div, add
    chk("R2", "op sub", st_op[0], 1); chk("R2", "op div", st_op[1], 3);
    chk("R2", "op mul", st_op[2], 2); chk("R2", "op add", st_op[4], 0);
    chk("R2", "operand a of div", st_a[1], r[1]);
    chk("R2", "operand b of div", st_b[1], r[2]);
    chk("R2", "operand a of add", st_a[4], r[5]);
    chk("R2", "operand b of add", st_b[4], r[6]);
    chk("R4", "move to move write gap", wr_cyc[1] - wr_cyc[0], 8);
    chk("R4", "write to start gap", st_cyc[0] - wr_cyc[1], 6);
    ai = '{2, 3, 5, 6, 7};
    for (int j = 0; j < 5; j++)
      chk("R4", "done to write gap", wr_cyc[ai[j]] - dn_cyc[j], 3);
    for (int j = 0; j < 4; j++)
      chk("R5", "start is one pulse per op", st_cyc[j + 1] > st_cyc[j] + 1, 1);
  endtask

  task automatic t_exception();
    int t1, t2, tg;
    logic prev;
    clear_prog();
    prog[0] = w_ar(5, 0, 0, 0); prog[1] = 16'h0000; prog[2] = 16'h0005;
    prog[3] = w_ar(5, 1, 0, 0); prog[4] = 16'h0000; prog[5] = 16'h0007;
    prog[6] = w_ar(1, 2, 0, 1);
    prog[7] = w_ar(5, 3, 0, 0);
    do_reset();
    exc_arm = 1;
    wait_stop();
    chk("R7", "suspended on exception", suspended, 1);
    chk("R7", "not halted", halted, 0);
    chk("R7", "blink low at entry", blink, 0);
    t1 = -1; t2 = -1; tg = 0; prev = blink;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (blink !== prev) begin
        if (tg == 1) t1 = cyc; else if (tg == 2) t2 = cyc;
        tg++;
      end
      prev = blink;
    end
    chk("R7", "blink period", t2 - t1, 1 << BL);
    chk("R7", "no write of faulting result", n_wr, 2);
    chk("R7", "pm_addr frozen", pm_addr, 7);
  endtask

  task automatic t_bad(logic [15:0] w);
    clear_prog();
    prog[0] = w;
    do_reset();
    wait_stop();
    repeat (4) @(negedge clk);
    chk("R8", "bad word suspends", suspended, 1);
    chk("R8", "bad word not halted", halted, 0);
    chk("R8", "bad word writes nothing", n_wr, 0);
  endtask

  task automatic t_recover();
    clear_prog();
    prog[0] = 16'hF000;
    do_reset();
    wait_stop();
    chk("R9", "suspended before reset", suspended, 1);
    prog[0] = 16'h0000;
    do_reset();
    chk("R9", "suspend cleared", suspended, 0);
    chk("R9", "restart at 0", pm_addr, 0);
    wait_stop();
    chk("R9", "halts after restart", halted, 1);
  endtask

  initial begin
    clear_prog();
    t_reset();
    t_program();
    t_exception();
    t_bad(16'h7000);
    t_bad(16'h0008);
    t_recover();
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule